// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a data line, a shift clock and a load strobe. All three lines are oversampled in the system clock domain and passed through a synchronizer. Each rising edge of the shift clock moves one data bit into a shift register. The most significant bit arrives first, so the bit that arrives last lands at position 0 and acts as the routing bit.

While the load strobe is high, the routing bit picks one of two holding registers. The reference register takes a divide ratio, a prescaler modulus select, a phase-detector polarity bit and an output-select bit. The main register takes a swallow count and a programmable count. Each register checks its values against a range before accepting them. A word that fails the check leaves the previous contents in place and raises an error flag for that register. The held fields drive the synthesizer's divider datapaths, which lie outside this block.

Top module: `pll_ser_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the shift register, and older bits move one place up. Bits are sent MSB first. Only the most recent 19 bits are kept, so earlier bits have no effect.
- R2: While `ser_le` is high and bit 0 is 1, the reference register is written as follows: `ref_ratio` takes bits 14..1, `ref_presc_hi` takes bit 15 (1 selects 128/129, 0 selects 64/65), `ref_pol` takes bit 16 and `ref_outsel` takes bit 17.
- R3: While `ser_le` is high and bit 0 is 0, the main register is written as follows: `main_swallow` takes bits 7..1 and `main_prog` takes bits 18..8.
- R4: While `ser_le` is low, every held output stays unchanged, whatever is shifted in.
- R5: A reference word with a ratio below 5 is rejected. The previous reference fields are kept and `ref_err` goes to 1. A valid reference load clears `ref_err`.
- R6: A main word is rejected if its programmable count is below 5 or if its swallow count is not less than its programmable count. The previous main fields are kept and `main_err` goes to 1. A valid main load clears `main_err`.
- R7: A synchronous reset clears the shift register, both registers and both error flags to zero.
- R8: A load to either register leaves the other register and its error flag unchanged.
- R9: The range ends are accepted: ratio 5 and 16383, programmable count 2047 with swallow count 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, active high |
| ref_ratio | output | 14 | Held reference divide ratio |
| ref_presc_hi | output | 1 | Prescaler select, 1 = 128/129 |
| ref_pol | output | 1 | Phase-detector polarity |
| ref_outsel | output | 1 | Output-select bit |
| main_swallow | output | 7 | Held swallow count |
| main_prog | output | 11 | Held programmable count |
| ref_err | output | 1 | Last reference load was rejected |
| main_err | output | 1 | Last main load was rejected |

## Verification
Faults inside the shift register stay hidden until the next load, because no output depends on the register before then. A misplaced or dropped bit then appears as a wrong field value a few system cycles after the strobe rises. A routing or range-check fault shows up in that same window: the wrong register changes, or a rejected value replaces a good one and the error flag stays low. The bench sends words with leading extra bits, words without a strobe and words at the range ends, so that each of these faults shows on the ports right after the load that exposes it.

// File: rtl/pll_ser_pkg.sv
package pll_ser_pkg;
   typedef enum logic {
      DEST_MAIN = 1'b0,
      DEST_REF  = 1'b1
   } dest_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pll_ser_sync.sv
module pll_ser_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial assert (STAGES >= 0 && STAGES <= 4) else $error("pll_ser_sync: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] st;
         always_ff @(posedge clk) begin
            if (rst) begin
               st <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pll_ser_shift.sv
module pll_ser_shift #(
   parameter int SR_W = 19
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sclk_s,
   input  logic            data_s,
   output logic            shift_en,
   output logic [SR_W-1:0] sr
);
   logic sclk_d;

   assign shift_en = sclk_s & ~sclk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d <= 1'b0;
         sr     <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (shift_en) sr <= {sr[SR_W-2:0], data_s};
      end
   end
endmodule

// File: rtl/pll_ser_dest.sv
module pll_ser_dest
   import pll_ser_pkg::*;
#(
   parameter int REF_RATIO_W   = 14,
   parameter int SWAL_W        = 7,
   parameter int PROG_W        = 11,
   parameter int REF_RATIO_MIN = 5,
   parameter int PROG_MIN      = 5,
   parameter bit REJECT_BAD    = 1'b1,
   parameter int SR_W          = 19
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   le_s,
   input  logic [SR_W-1:0]        sr,
   output logic [REF_RATIO_W-1:0] ref_ratio,
   output logic                   ref_presc_hi,
   output logic                   ref_pol,
   output logic                   ref_outsel,
   output logic [SWAL_W-1:0]      main_swallow,
   output logic [PROG_W-1:0]      main_prog,
   output logic                   ref_err,
   output logic                   main_err
);
   localparam int CMP_W = max_int(SWAL_W, PROG_W) + 1;
   localparam int PRE_B = REF_RATIO_W + 1;
   localparam int POL_B = REF_RATIO_W + 2;
   localparam int OUT_B = REF_RATIO_W + 3;
   localparam logic [REF_RATIO_W-1:0] REF_MIN_V  = REF_RATIO_W'(REF_RATIO_MIN);
   localparam logic [PROG_W-1:0]      PROG_MIN_V = PROG_W'(PROG_MIN);

   initial assert (OUT_B < SR_W && SWAL_W + PROG_W < SR_W)
      else $error("pll_ser_dest: shift register too narrow");

   dest_e                   dest;
   logic [REF_RATIO_W-1:0]  w_ratio;
   logic [SWAL_W-1:0]       w_swal;
   logic [PROG_W-1:0]       w_prog;
   logic                    ref_ok;
   logic                    main_ok;
   logic                    ref_take;
   logic                    main_take;

   assign dest    = dest_e'(sr[0]);
   assign w_ratio = sr[REF_RATIO_W:1];
   assign w_swal  = sr[SWAL_W:1];
   assign w_prog  = sr[SWAL_W+PROG_W:SWAL_W+1];
   assign ref_ok  = (w_ratio >= REF_MIN_V);
   assign main_ok = (w_prog >= PROG_MIN_V) && (CMP_W'(w_swal) < CMP_W'(w_prog));

   generate
      if (REJECT_BAD) begin : g_reject
         assign ref_take  = ref_ok;
         assign main_take = main_ok;
      end else begin : g_accept
         assign ref_take  = 1'b1;
         assign main_take = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_ratio    <= '0;
         ref_presc_hi <= 1'b0;
         ref_pol      <= 1'b0;
         ref_outsel   <= 1'b0;
         ref_err      <= 1'b0;
      end else if (le_s && dest == DEST_REF) begin
         ref_err <= ~ref_ok;
         if (ref_take) begin
            ref_ratio    <= w_ratio;
            ref_presc_hi <= sr[PRE_B];
            ref_pol      <= sr[POL_B];
            ref_outsel   <= sr[OUT_B];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         main_swallow <= '0;
         main_prog    <= '0;
         main_err     <= 1'b0;
      end else if (le_s && dest == DEST_MAIN) begin
         main_err <= ~main_ok;
         if (main_take) begin
            main_swallow <= w_swal;
            main_prog    <= w_prog;
         end
      end
   end
endmodule

// File: rtl/pll_ser_loader.sv
module pll_ser_loader
   import pll_ser_pkg::*;
#(
   parameter int REF_RATIO_W   = 14,
   parameter int SWAL_W        = 7,
   parameter int PROG_W        = 11,
   parameter int REF_RATIO_MIN = 5,
   parameter int PROG_MIN      = 5,
   parameter bit REJECT_BAD    = 1'b1,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   ser_clk,
   input  logic                   ser_data,
   input  logic                   ser_le,
   output logic [REF_RATIO_W-1:0] ref_ratio,
   output logic                   ref_presc_hi,
   output logic                   ref_pol,
   output logic                   ref_outsel,
   output logic [SWAL_W-1:0]      main_swallow,
   output logic [PROG_W-1:0]      main_prog,
   output logic                   ref_err,
   output logic                   main_err
);
   localparam int REF_WORD_W  = 1 + REF_RATIO_W + 3;
   localparam int MAIN_WORD_W = 1 + SWAL_W + PROG_W;
   localparam int SR_W        = max_int(REF_WORD_W, MAIN_WORD_W);

   initial assert (REF_RATIO_MIN >= 1 && REF_RATIO_MIN < (1 << REF_RATIO_W))
      else $error("pll_ser_loader: REF_RATIO_MIN out of range");
   initial assert (PROG_MIN >= 1 && PROG_MIN < (1 << PROG_W))
      else $error("pll_ser_loader: PROG_MIN out of range");

   logic [2:0]      sync_q;
   logic            sclk_s;
   logic            data_s;
   logic            le_s;
   logic            shift_en;
   logic [SR_W-1:0] sr;

   pll_ser_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   ({ser_le, ser_data, ser_clk}),
      .q   (sync_q)
   );

   assign sclk_s = sync_q[0];
   assign data_s = sync_q[1];
   assign le_s   = sync_q[2];

   pll_ser_shift #(.SR_W(SR_W)) shift_i (
      .clk      (clk),
      .rst      (rst),
      .sclk_s   (sclk_s),
      .data_s   (data_s),
      .shift_en (shift_en),
      .sr       (sr)
   );

   pll_ser_dest #(
      .REF_RATIO_W   (REF_RATIO_W),
      .SWAL_W        (SWAL_W),
      .PROG_W        (PROG_W),
      .REF_RATIO_MIN (REF_RATIO_MIN),
      .PROG_MIN      (PROG_MIN),
      .REJECT_BAD    (REJECT_BAD),
      .SR_W          (SR_W)
   ) dest_i (
      .clk          (clk),
      .rst          (rst),
      .le_s         (le_s),
      .sr           (sr),
      .ref_ratio    (ref_ratio),
      .ref_presc_hi (ref_presc_hi),
      .ref_pol      (ref_pol),
      .ref_outsel   (ref_outsel),
      .main_swallow (main_swallow),
      .main_prog    (main_prog),
      .ref_err      (ref_err),
      .main_err     (main_err)
   );
endmodule

// File: rtl/pll_ser_loader_chk.sv
module pll_ser_loader_chk #(
   parameter int REF_RATIO_W   = 14,
   parameter int SWAL_W        = 7,
   parameter int PROG_W        = 11,
   parameter int REF_RATIO_MIN = 5,
   parameter int PROG_MIN      = 5,
   parameter bit REJECT_BAD    = 1'b1
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   le_s,
   input logic                   shift_en,
   input logic                   data_s,
   input logic                   sr0,
   input logic                   sr1,
   input logic [REF_RATIO_W-1:0] ref_ratio,
   input logic                   ref_presc_hi,
   input logic                   ref_pol,
   input logic                   ref_outsel,
   input logic [SWAL_W-1:0]      main_swallow,
   input logic [PROG_W-1:0]      main_prog,
   input logic                   ref_err,
   input logic                   main_err
);
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   a_r1_shift_entry: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (sr0 == $past(data_s)) && (sr1 == $past(sr0)));

   a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !le_s |=> $stable(ref_ratio) && $stable(ref_presc_hi) && $stable(ref_pol) &&
                $stable(ref_outsel) && $stable(main_swallow) && $stable(main_prog) &&
                $stable(ref_err) && $stable(main_err));

   a_r8_ref_spares_main: assert property (@(posedge clk) disable iff (rst)
      (le_s && sr0) |=> $stable(main_swallow) && $stable(main_prog) && $stable(main_err));

   a_r8_main_spares_ref: assert property (@(posedge clk) disable iff (rst)
      (le_s && !sr0) |=> $stable(ref_ratio) && $stable(ref_presc_hi) && $stable(ref_err));

   generate
      if (REJECT_BAD) begin : g_range
         a_r5_ref_ratio_range: assert property (@(posedge clk) disable iff (rst)
            (ref_ratio == '0) || (int'(ref_ratio) >= REF_RATIO_MIN));
         a_r6_main_order: assert property (@(posedge clk) disable iff (rst)
            (main_prog == '0) ||
            (int'(main_prog) >= PROG_MIN && int'(main_swallow) < int'(main_prog)));
      end
   endgenerate

   always @(posedge clk) begin
      if (rst_q) begin
         a_r7_reset_clear: assert (ref_ratio == '0 && !ref_presc_hi && !ref_pol && !ref_outsel &&
                                   main_swallow == '0 && main_prog == '0 && !ref_err && !main_err);
      end
   end
endmodule

bind pll_ser_loader pll_ser_loader_chk #(
   .REF_RATIO_W   (REF_RATIO_W),
   .SWAL_W        (SWAL_W),
   .PROG_W        (PROG_W),
   .REF_RATIO_MIN (REF_RATIO_MIN),
   .PROG_MIN      (PROG_MIN),
   .REJECT_BAD    (REJECT_BAD)
) chk_i (
   .clk          (clk),
   .rst          (rst),
   .le_s         (le_s),
   .shift_en     (shift_en),
   .data_s       (data_s),
   .sr0          (sr[0]),
   .sr1          (sr[1]),
   .ref_ratio    (ref_ratio),
   .ref_presc_hi (ref_presc_hi),
   .ref_pol      (ref_pol),
   .ref_outsel   (ref_outsel),
   .main_swallow (main_swallow),
   .main_prog    (main_prog),
   .ref_err      (ref_err),
   .main_err     (main_err)
);

// File: tb/pll_ser_loader_tb_top.sv
module pll_ser_loader_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk = 1'b0;
   logic ser_data = 1'b0;
   logic ser_le = 1'b0;
   logic [13:0] ref_ratio;
   logic        ref_presc_hi, ref_pol, ref_outsel;
   logic [6:0]  main_swallow;
   logic [10:0] main_prog;
   logic        ref_err, main_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pll_ser_loader dut_i (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .ref_ratio(ref_ratio), .ref_presc_hi(ref_presc_hi), .ref_pol(ref_pol),
      .ref_outsel(ref_outsel), .main_swallow(main_swallow), .main_prog(main_prog),
      .ref_err(ref_err), .main_err(main_err)
   );

   // flags field: {outsel, pol, presc_hi}
   typedef struct packed {
      logic        is_ref;
      logic [13:0] ratio;
      logic [2:0]  flags;
      logic [6:0]  swal;
      logic [10:0] prog;
      logic [13:0] e_ratio;
      logic [2:0]  e_flags;
      logic [6:0]  e_swal;
      logic [10:0] e_prog;
      logic        e_rerr;
      logic        e_merr;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1, 14'd1000,  3'b101, 7'd0,   11'd0,    14'd1000,  3'b101, 7'd0,   11'd0,    1'b0, 1'b0},
      '{1'b0, 14'd0,     3'b000, 7'd20,  11'd100,  14'd1000,  3'b101, 7'd20,  11'd100,  1'b0, 1'b0},
      '{1'b1, 14'd4,     3'b010, 7'd0,   11'd0,    14'd1000,  3'b101, 7'd20,  11'd100,  1'b1, 1'b0},
      '{1'b1, 14'd5,     3'b011, 7'd0,   11'd0,    14'd5,     3'b011, 7'd20,  11'd100,  1'b0, 1'b0},
      '{1'b0, 14'd0,     3'b000, 7'd0,   11'd4,    14'd5,     3'b011, 7'd20,  11'd100,  1'b0, 1'b1},
      '{1'b0, 14'd0,     3'b000, 7'd30,  11'd30,   14'd5,     3'b011, 7'd20,  11'd100,  1'b0, 1'b1},
      '{1'b0, 14'd0,     3'b000, 7'd127, 11'd2047, 14'd5,     3'b011, 7'd127, 11'd2047, 1'b0, 1'b0},
      '{1'b1, 14'd16383, 3'b111, 7'd0,   11'd0,    14'd16383, 3'b111, 7'd127, 11'd2047, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) ser_data = b;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_word(input logic [18:0] w, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic strobe();
      @(negedge clk) ser_le = 1'b1;
      repeat (4) @(negedge clk);
      ser_le = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [18:0] ref_word(input logic [13:0] r, input logic [2:0] f);
      return {1'b0, f, r, 1'b1};
   endfunction

   function automatic logic [18:0] main_word(input logic [10:0] p, input logic [6:0] s);
      return {p, s, 1'b0};
   endfunction

   task automatic chk_all(input string req, input vec_t v);
      chk(req, 32'(ref_ratio), 32'(v.e_ratio));
      chk(req, 32'({ref_outsel, ref_pol, ref_presc_hi}), 32'(v.e_flags));
      chk(req, 32'(main_swallow), 32'(v.e_swal));
      chk(req, 32'(main_prog), 32'(v.e_prog));
      chk(req, 32'(ref_err), 32'(v.e_rerr));
      chk(req, 32'(main_err), 32'(v.e_merr));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      vec_t z;
      string req;
      z = '0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      // R7: reset state
      chk_all("R7 reset", z);

      // vector table: R2, R3, R5, R6, R8, R9
      for (int k = 0; k < NV; k++) begin
         if (VEC[k].is_ref) begin
            req = VEC[k].e_rerr ? "R5 ref reject" : "R2 R9 ref load";
            send_word(ref_word(VEC[k].ratio, VEC[k].flags), 18);
         end else begin
            req = VEC[k].e_merr ? "R6 main reject" : "R3 R9 main load";
            send_word(main_word(VEC[k].prog, VEC[k].swal), 19);
         end
         strobe();
         chk_all(req, VEC[k]);
      end

      // R4: shifting with load strobe low changes nothing
      send_word(ref_word(14'd777, 3'b000), 18);
      repeat (10) @(negedge clk);
      chk_all("R4 no strobe", VEC[NV-1]);

      // R1: leading surplus bits are pushed out; only last 19 count
      send_word(19'h7FFFF, 6);
      send_word(main_word(11'd300, 7'd45), 19);
      strobe();
      chk("R1 prog", 32'(main_prog), 32'd300);
      chk("R1 swallow", 32'(main_swallow), 32'd45);
      chk("R8 ref kept", 32'(ref_ratio), 32'd16383);

      // R7: reset mid-operation clears everything
      @(negedge clk) rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk_all("R7 reset again", z);
      // R7: shift register cleared, strobe alone loads zero word to main (prog 0 rejected)
      strobe();
      chk("R7 sr cleared main_err", 32'(main_err), 32'd1);
      chk("R7 sr cleared prog", 32'(main_prog), 32'd0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule